// File: doc/BRIEF.md
# Passive LCD AC-Drive Alternation and Frame-Freeze Controller

This block produces the alternating drive level that a passive LCD panel needs to keep DC off the liquid crystal, and a strobe that tells the frame-rate-modulation (FRM) logic to hold its pattern for one frame. It watches a per-line pulse and a per-frame pulse from an external timing generator. A six-bit rate value sets the alternation. When the value is zero, the level flips on each frame pulse. When it is non-zero, the level flips once per that many line pulses.

For electroluminescent panels, a long-period frame counter can be enabled. Once per `FREEZE_PERIOD` frames, the block raises a hold strobe for exactly one frame. During that frame the FRM logic repeats its previous output, so two consecutive frames are identical. A small write/read register port holds the rate value and the panel configuration bits. A mode input tells the block whether the shared drive pin is used for alternation. Selecting a TFT panel forces both outputs inactive.

Top module: `lcd_mod_ctrl`

## Requirements
- R1: After reset, `modOut` and `frmHold` are 0, and both registers read back as 0x00.
- R2: Register address 0 is the panel configuration. Bit 7 is the EL-mode enable and bit 0 is the TFT select (1 = TFT, 0 = passive); its other bits read 0. Address 1 is the rate register, held in bits [5:0], with bits [7:6] reading 0. Writes take effect on the clock edge where `cfgWrEn` is high.
- R3: With rate 0, `modOut` inverts in the cycle after every `framePulse`, and line pulses do not change it.
- R4: With a rate N from 1 to 63, `modOut` inverts in the cycle after the N-th `linePulse` counted since the previous inversion, and frame pulses do not change it.
- R5: A write to the rate register clears the line count. A line pulse in the same cycle as that write is neither counted nor causes an inversion.
- R6: While `modPinSel` is 0, `modOut` is 0 from the next cycle on, and the line count is cleared. When `modPinSel` returns to 1, alternation restarts from a low level with an empty count.
- R7: While TFT is selected, `modOut` and `frmHold` are 0 from the next cycle on.
- R8: With EL mode enabled on a passive panel, `frmHold` rises in the cycle after every `FREEZE_PERIOD`-th frame pulse. It stays high until the cycle after the following frame pulse, which starts a new count.
- R9: While EL mode is disabled, the frame count is cleared and `frmHold` is 0 from the next cycle on. After it is re-enabled, the first hold follows the `FREEZE_PERIOD`-th new frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 1 | Register select: 0 panel configuration, 1 rate |
| cfgWrData | input | 8 | Register write data |
| cfgRdData | output | 8 | Read data of the selected register (combinational) |
| modPinSel | input | 1 | 1 when the shared drive pin is used for alternation |
| linePulse | input | 1 | One-cycle pulse per panel line |
| framePulse | input | 1 | One-cycle pulse per panel frame |
| modOut | output | 1 | Alternation level to the panel |
| frmHold | output | 1 | High for the one frame in which FRM must repeat |

## Verification
The assertions assume that `linePulse` and `framePulse` are single-cycle events, and that every change of `modOut` and `frmHold` can be traced to a pulse, a register write or a mode input in the previous cycle. The random stimulus keeps pulses to one cycle each, although they may land in the same cycle as each other or as a register write. That lets it reach the collision cases of R5 on purpose. The bench shortens `FREEZE_PERIOD` so that many holds happen within the run. It toggles `modPinSel`, TFT select and EL enable only occasionally, so that long stretches of normal counting happen between mode changes.

// File: rtl/lcd_mod_pkg.sv
package lcd_mod_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrLine;
    logic incLine;
    logic toggleMod;
    logic clrMod;
    logic clrFrame;
    logic incFrame;
    logic setHold;
    logic clrHold;
  } modStrobes_t;

  localparam logic CFG_ADDR_PANEL = 1'b0;
  localparam logic CFG_ADDR_RATE  = 1'b1;
  localparam int   EL_BIT         = 7;
  localparam int   TFT_BIT        = 0;

endpackage

// File: rtl/lmc_regs.sv
module lmc_regs #(
  parameter int RATE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [RATE_W-1:0] rate,
  output logic              elEn,
  output logic              tftSel,
  output logic              rateWr
);
  import lcd_mod_pkg::*;

  logic panelWr;

  assign panelWr = wrEn && (addr == CFG_ADDR_PANEL);
  assign rateWr  = wrEn && (addr == CFG_ADDR_RATE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rate   <= '0;
      elEn   <= 1'b0;
      tftSel <= 1'b0;
    end else begin
      if (rateWr) rate <= wrData[RATE_W-1:0];
      if (panelWr) begin
        elEn   <= wrData[EL_BIT];
        tftSel <= wrData[TFT_BIT];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == CFG_ADDR_RATE) begin
      rdData[RATE_W-1:0] = rate;
    end else begin
      rdData[EL_BIT]  = elEn;
      rdData[TFT_BIT] = tftSel;
    end
  end

endmodule

// File: rtl/lmc_ctrl.sv
module lmc_ctrl #(
  parameter int RATE_W = 6
) (
  input  logic                      modPinSel,
  input  logic                      tftSel,
  input  logic                      elEn,
  input  logic [RATE_W-1:0]         rate,
  input  logic                      rateWr,
  input  logic                      linePulse,
  input  logic                      framePulse,
  input  logic                      lineHit,
  input  logic                      frameHit,
  output lcd_mod_pkg::modStrobes_t  strb
);

  logic modActive;
  logic elActive;
  logic frameMode;
  logic lineCountable;

  assign modActive     = modPinSel && !tftSel;
  assign elActive      = elEn && !tftSel;
  assign frameMode     = (rate == '0);
  assign lineCountable = modActive && !frameMode && linePulse && !rateWr;

  always_comb begin
    strb = '0;
    // alternation path
    strb.clrMod    = !modActive;
    strb.toggleMod = modActive && ((frameMode && framePulse) || (lineCountable && lineHit));
    strb.clrLine   = !modActive || rateWr || frameMode || (lineCountable && lineHit);
    strb.incLine   = lineCountable && !lineHit;
    // freeze path
    strb.setHold   = elActive && framePulse && frameHit;
    strb.clrHold   = !elActive || framePulse;
    strb.clrFrame  = !elActive || (framePulse && frameHit);
    strb.incFrame  = elActive && framePulse && !frameHit;
  end

endmodule

// File: rtl/lmc_datapath.sv
module lmc_datapath #(
  parameter int RATE_W        = 6,
  parameter int FRAME_W       = 18,
  parameter int FREEZE_PERIOD = 262143
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lcd_mod_pkg::modStrobes_t strb,
  input  logic [RATE_W-1:0]        rate,
  output logic                     lineHit,
  output logic                     frameHit,
  output logic                     modOut,
  output logic                     frmHold
);

  localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FREEZE_PERIOD - 1);

  logic [RATE_W-1:0]  lineCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic [RATE_W:0]    lineNext;

  assign lineNext = {1'b0, lineCnt} + 1'b1;
  assign lineHit  = (lineNext == {1'b0, rate});
  assign frameHit = (frameCnt == FRAME_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
      modOut  <= 1'b0;
    end else begin
      if (strb.clrLine)      lineCnt <= '0;
      else if (strb.incLine) lineCnt <= lineNext[RATE_W-1:0];
      if (strb.clrMod)         modOut <= 1'b0;
      else if (strb.toggleMod) modOut <= !modOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      frmHold  <= 1'b0;
    end else begin
      if (strb.clrFrame)      frameCnt <= '0;
      else if (strb.incFrame) frameCnt <= frameCnt + 1'b1;
      if (strb.setHold)      frmHold <= 1'b1;
      else if (strb.clrHold) frmHold <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_mod_ctrl.sv
module lcd_mod_ctrl #(
  parameter int RATE_W        = 6,
  parameter int DATA_W        = 8,
  parameter int FRAME_W       = 18,
  parameter int FREEZE_PERIOD = 262143
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              modPinSel,
  input  logic              linePulse,
  input  logic              framePulse,
  output logic              modOut,
  output logic              frmHold
);

  lcd_mod_pkg::modStrobes_t strb;
  logic [RATE_W-1:0] rate;
  logic elEn;
  logic tftSel;
  logic rateWr;
  logic lineHit;
  logic frameHit;

  lmc_regs #(.RATE_W(RATE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .addr(cfgAddr),
    .wrData(cfgWrData), .rdData(cfgRdData), .rate(rate),
    .elEn(elEn), .tftSel(tftSel), .rateWr(rateWr)
  );

  lmc_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .modPinSel(modPinSel), .tftSel(tftSel), .elEn(elEn), .rate(rate),
    .rateWr(rateWr), .linePulse(linePulse), .framePulse(framePulse),
    .lineHit(lineHit), .frameHit(frameHit), .strb(strb)
  );

  lmc_datapath #(.RATE_W(RATE_W), .FRAME_W(FRAME_W), .FREEZE_PERIOD(FREEZE_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rate(rate),
    .lineHit(lineHit), .frameHit(frameHit), .modOut(modOut), .frmHold(frmHold)
  );

endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int RATE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              modPinSel,
  input logic              linePulse,
  input logic              framePulse,
  input logic              cfgWrEn,
  input logic              modOut,
  input logic              frmHold,
  input logic              tftSel,
  input logic              elEn,
  input logic [RATE_W-1:0] rate
);

  // R6: pin not used for alternation drives the level low
  p_mod_low_unsel_r6: assert property (@(posedge clk) disable iff (!rstN)
    !modPinSel |=> !modOut);

  // R7: TFT forces both outputs low
  p_tft_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    tftSel |=> (!modOut && !frmHold));

  // R9: EL disabled keeps the hold low
  p_hold_off_el_r9: assert property (@(posedge clk) disable iff (!rstN)
    !elEn |=> !frmHold);

  // R3: rate zero inverts the level after a frame pulse
  p_frame_toggle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rate == '0 && framePulse && modPinSel && !tftSel) |=> (modOut != $past(modOut)));

  // R3/R4: the level only moves after a pulse, a write or a mode input
  p_mod_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modOut) |-> $past(linePulse || framePulse || !modPinSel || tftSel || cfgWrEn));

  // R8: the hold only starts after a frame pulse
  p_hold_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmHold) |-> $past(framePulse));

  // R8: the hold ends after a frame pulse or a mode change
  p_hold_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frmHold) |-> $past(framePulse || !elEn || tftSel));

endmodule

bind lcd_mod_ctrl lmc_checker #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rstN(rstN), .modPinSel(modPinSel), .linePulse(linePulse),
  .framePulse(framePulse), .cfgWrEn(cfgWrEn), .modOut(modOut),
  .frmHold(frmHold), .tftSel(tftSel), .elEn(elEn), .rate(rate)
);

// File: tb/tb_lcd_mod_ctrl.sv
module tb_lcd_mod_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic cfgAddr = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic modPinSel = 1'b1;
  logic linePulse = 1'b0;
  logic framePulse = 1'b0;
  logic modOut;
  logic frmHold;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  bit expMod = 0, expHold = 0, mEl = 0, mTft = 0;
  int expLine = 0, expFrame = 0, mRate = 0;

  lcd_mod_ctrl #(.FREEZE_PERIOD(PERIOD)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .modPinSel(modPinSel),
    .linePulse(linePulse), .framePulse(framePulse), .modOut(modOut),
    .frmHold(frmHold)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int expRead(bit a);
    return a ? (mRate & 63) : ((int'(mEl) << 7) | int'(mTft));
  endfunction

  // One clock: inputs applied, reference advanced at the edge, outputs compared after it
  task automatic cycle(string tag, bit lp, bit fp, bit wr = 0, bit a = 0, int d = 0);
    bit act, elAct;
    linePulse = lp; framePulse = fp; cfgWrEn = wr; cfgAddr = a; cfgWrData = d[7:0];
    @(posedge clk);
    act = modPinSel && !mTft;
    if (!act) begin
      expMod = 0; expLine = 0;
    end else if (mRate == 0) begin
      expLine = 0;
      if (fp) expMod = !expMod;
    end else if (wr && a) begin
      expLine = 0;
    end else if (lp) begin
      if (expLine + 1 == mRate) begin expMod = !expMod; expLine = 0; end
      else expLine++;
    end
    elAct = mEl && !mTft;
    if (!elAct) begin
      expFrame = 0; expHold = 0;
    end else if (fp) begin
      if (expFrame == PERIOD - 1) begin expHold = 1; expFrame = 0; end
      else begin expFrame++; expHold = 0; end
    end
    if (wr) begin
      if (a) mRate = d & 63;
      else begin mEl = d[7]; mTft = d[0]; end
    end
    #1;
    linePulse = 0; framePulse = 0; cfgWrEn = 0;
    check(tag, "modOut", modOut, expMod);
    check(tag, "frmHold", frmHold, expHold);
  endtask

  task automatic readCheck(string tag, bit a);
    cfgAddr = a;
    #1;
    check(tag, a ? "rate read" : "panel read", cfgRdData, expRead(a));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "modOut", modOut, 0);
    check("R1", "frmHold", frmHold, 0);
    cfgAddr = 0; #1; check("R1", "panel read", cfgRdData, 0);
    cfgAddr = 1; #1; check("R1", "rate read", cfgRdData, 0);
    rstN = 1;
    @(negedge clk);

    // R2 register readback, unused bits read zero
    cycle("R2", 0, 0, 1, 0, 8'hFF); readCheck("R2", 0);
    cycle("R2", 0, 0, 1, 1, 8'hFF); readCheck("R2", 1);
    cycle("R2", 0, 0, 1, 0, 8'h00); readCheck("R2", 0);
    cycle("R2", 0, 0, 1, 1, 8'h00); readCheck("R2", 1);

    // R3 rate zero: frames toggle, lines do not
    for (int i = 0; i < 6; i++) begin
      cycle("R3", 1, 0); cycle("R3", 1, 0); cycle("R3", 0, 1);
    end
    cycle("R3", 1, 1);

    // R4 rate 3: every third line toggles, frames ignored
    cycle("R4", 0, 0, 1, 1, 3);
    for (int i = 0; i < 12; i++) cycle("R4", 1, (i % 4) == 0);
    // R4 boundary rates 1 and 63
    cycle("R4", 0, 0, 1, 1, 1);
    for (int i = 0; i < 5; i++) cycle("R4", 1, 0);
    cycle("R4", 0, 0, 1, 1, 63);
    for (int i = 0; i < 130; i++) cycle("R4", 1, 0);

    // R5 rate write clears the count; colliding line pulse not counted
    cycle("R5", 0, 0, 1, 1, 4);
    cycle("R5", 1, 0); cycle("R5", 1, 0); cycle("R5", 1, 0);
    cycle("R5", 1, 0, 1, 1, 4);
    for (int i = 0; i < 5; i++) cycle("R5", 1, 0);

    // R6 pin not used for alternation
    modPinSel = 0;
    for (int i = 0; i < 6; i++) cycle("R6", 1, 1);
    modPinSel = 1;
    for (int i = 0; i < 6; i++) cycle("R6", 1, 0);

    // R8 EL hold period
    cycle("R8", 0, 0, 1, 0, 8'h80);
    for (int i = 0; i < 3 * PERIOD + 2; i++) begin
      cycle("R8", 0, 1); cycle("R8", 1, 0); cycle("R8", 0, 0);
    end

    // R9 disable clears the frame count
    cycle("R9", 0, 1); cycle("R9", 0, 1);
    cycle("R9", 0, 0, 1, 0, 8'h00);
    for (int i = 0; i < 3; i++) cycle("R9", 0, 1);
    cycle("R9", 0, 0, 1, 0, 8'h80);
    for (int i = 0; i < 2 * PERIOD; i++) begin cycle("R9", 0, 1); cycle("R9", 0, 0); end

    // R7 TFT forces outputs low
    cycle("R7", 0, 0, 1, 0, 8'h81);
    for (int i = 0; i < 3 * PERIOD; i++) cycle("R7", 1, 1);
    cycle("R7", 0, 0, 1, 0, 8'h80);

    // random mix across R3/R4/R5/R8
    for (int i = 0; i < 4000; i++) begin
      int r, d;
      bit wr, a;
      r = $urandom % 100;
      wr = ($urandom % 40) == 0;
      a = ($urandom % 4) != 0;
      d = a ? (($urandom % 3 == 0) ? 0 : int'($urandom % 8)) : (($urandom % 5 == 0) ? 1 : 0) | 8'h80;
      if (($urandom % 300) == 0) modPinSel = !modPinSel;
      cycle("R3/R4/R8", r < 35, (r % 13) == 0, wr, a, d);
    end
    modPinSel = 1;
    readCheck("R2", 1);
    readCheck("R2", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule